// File: doc/BRIEF.md
# Framer reset and transparent-mode controller

This block holds the 8-bit reset and transparency control word of one T1/E1 framer channel. It turns software writes into the line-side controls that the framers obey. A self-timed soft reset holds both the framer and the data-link sections in reset for a fixed number of receive-line clocks. A level-held restart keeps both sections in reset for as long as its bit stays set. A reframe command fires once, and only when its bit rises. Two transparency enables and a system-sync mask complete the control word.

The register sits in the register clock domain, and the reset timing runs on the receive-line clock. Levels cross between the two through multi-flop synchronisers, and the two one-time commands cross as toggles. The soft-reset bit reads back as 1 until the line side returns an acknowledge toggle. In transparent operation the block steers the serial streams between the system and line sides. On a DS1 line it moves the framing bit to or from bit 7 of time slot 0. On an E1 line time slot 0 passes along with the rest of the frame.

Top module: `frm_mode_ctrl`

## Requirements
- R1: After `rst` the register reads 0x00. Bits 7:6 always read 0. Bits 5:1 read back the value last written.
- R2: A write with bit 0 = 1 drives `sec_rst` and `frm_param_clr` high for exactly SRST_CYCLES (default 4) `lclk` cycles. Bit 0 reads 1 until that window ends and then returns to 0 by itself.
- R3: While bit 1 is 1, `sec_rst` and `dl_param_clr` stay high and `frm_param_clr` stays low. Both are released once bit 1 is written to 0.
- R4: With bit 1 already set, a soft reset still drives `frm_param_clr` for exactly SRST_CYCLES cycles, and `sec_rst` stays high throughout and afterwards while bit 1 is still set.
- R5: A write that changes bit 2 from 0 to 1 produces exactly one one-cycle `reframe` pulse in the `lclk` domain. Writing 1 to bit 2 while it is already 1 produces none.
- R6: With bit 3 = 1, `align_block` is 1, `line_out` follows `sys_in` and `sys_out` follows `line_in`, except at the DS1 framing positions covered by R8.
- R7: With bit 4 = 1 and bit 3 = 0, `line_out` follows `sys_in`, `sys_out` carries `rx_framed` and `align_block` is 0. When both bits are set, bit 3 decides.
- R8: In DS1 (`e1_mode` = 0) transmit transparency, `line_out` at `line_fpos` carries the `sys_in` value captured at the most recent `sys_ts0b7` strobe. With bit 3 set, `sys_out` at `sys_ts0b7` carries the `line_in` value captured at the most recent `line_fpos` strobe.
- R9: In E1 (`e1_mode` = 1) transparency no bit is substituted: time slot 0 is copied whole, as is every other slot.
- R10: With bits 3 and 4 both 0, `line_out` equals `tx_framed`, `sys_out` equals `rx_framed` and `align_block` is 0.
- R11: With bit 5 = 1, `sync_in` reaches `tx_sync` until a first pulse has been seen since `lrst` or since the end of the last `sec_rst`. Later pulses are blocked. With bit 5 = 0 every pulse passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset, register domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| lclk | input | 1 | Receive-line clock |
| lrst | input | 1 | Synchronous active-high reset, line domain |
| sec_rst | output | 1 | Reset to framer and data-link sections |
| frm_param_clr | output | 1 | Restore framer parameter registers to defaults |
| dl_param_clr | output | 1 | Restore data-link parameter registers to defaults |
| reframe | output | 1 | One-cycle force into loss of frame alignment |
| align_block | output | 1 | Forbid receive alignment (bidirectional transparency) |
| sync_in | input | 1 | System frame-sync pulse |
| tx_sync | output | 1 | Frame sync passed to the transmit framer |
| e1_mode | input | 1 | 1 = E1 frame, 0 = DS1 frame |
| sys_ts0b7 | input | 1 | System-side strobe: current bit is time slot 0 bit 7 |
| line_fpos | input | 1 | Line-side strobe: current bit is the F-bit position |
| sys_in | input | 1 | Serial system data toward the line |
| tx_framed | input | 1 | Transmit framer's normal line data |
| line_out | output | 1 | Serial line data out |
| line_in | input | 1 | Serial line data in |
| rx_framed | input | 1 | Receive framer's normal system data |
| sys_out | output | 1 | Serial system data out |

## Verification
The assertions watch, on every cycle, the things a single edge can show. They check the register readback after each write, the exact length of the parameter-restore window, and that a held restart keeps the sections in reset. They also check that `tx_sync` is only ever a copy of `sync_in` and is withheld only after a pulse has been seen, and that bidirectional transparency copies line data to the system side. The bench scenarios are needed to show the behaviour that spans both clock domains. That covers the self-clear of bit 0 after the handshake, that a reframe fires once per rising write and never on a repeat, the overlap of soft reset and restart, and the carry of a captured framing bit from one strobe to a later one across a sweep of modes and frame types.

// File: rtl/frm_ctrl_pkg.sv
package frm_ctrl_pkg;

    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] WR_MASK = 8'h3F;

    // Field order is the software-visible bit layout.
    typedef struct packed {
        logic [1:0] rsvd;       // 7:6
        logic       sync_mask;  // 5
        logic       tx_only;    // 4
        logic       bidir;      // 3
        logic       reframe;    // 2
        logic       restart;    // 1
        logic       soft_rst;   // 0
    } ctl_reg_t;

    typedef enum logic [1:0] {
        PASS_NONE = 2'd0,
        PASS_TX   = 2'd1,
        PASS_BOTH = 2'd2
    } transp_e;

    function automatic ctl_reg_t mask_write(input logic [REG_W-1:0] w);
        return ctl_reg_t'(w & WR_MASK);
    endfunction

    // The bidirectional enable outranks transmit-only.
    function automatic transp_e decode_transp(input logic bidir, input logic tx_only);
        if (bidir)
            return PASS_BOTH;
        else if (tx_only)
            return PASS_TX;
        else
            return PASS_NONE;
    endfunction

endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[s] <= '0;
                else     st[s] <= st[s-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/frm_regs.sv
module frm_regs
    import frm_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             srst_ack,
    output ctl_reg_t         ctl,
    output logic             srst_req,
    output logic             rfr_req
);
    ctl_reg_t wv;
    ctl_reg_t nxt;
    logic     srst_start;
    logic     rfr_rise;
    logic     srst_done;

    always_comb begin
        wv         = mask_write(wr_data);
        srst_start = wr_en && wv.soft_rst && !ctl.soft_rst;
        rfr_rise   = wr_en && wv.reframe && !ctl.reframe;
        // The line side echoes the request toggle once its window has ended.
        srst_done  = ctl.soft_rst && (srst_ack == srst_req);

        nxt = ctl;
        if (wr_en) begin
            nxt          = wv;
            nxt.soft_rst = ctl.soft_rst | srst_start;
        end
        if (srst_done)
            nxt.soft_rst = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            srst_req <= 1'b0;
            rfr_req  <= 1'b0;
        end else begin
            ctl <= nxt;
            if (srst_start) srst_req <= ~srst_req;
            if (rfr_rise)   rfr_req  <= ~rfr_req;
        end
    end
endmodule

// File: rtl/frm_line_seq.sv
module frm_line_seq #(
    parameter int SRST_CYCLES = 4
) (
    input  logic lclk,
    input  logic lrst,
    input  logic srst_req_s,
    input  logic rfr_req_s,
    input  logic restart_s,
    input  logic mask_s,
    input  logic sync_in,
    output logic srst_ack,
    output logic sec_rst,
    output logic frm_param_clr,
    output logic dl_param_clr,
    output logic reframe,
    output logic tx_sync
);
    localparam int CW = $clog2(SRST_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          srst_req_q;
    logic          rfr_req_q;
    logic          seen_sync;
    logic          soft_active;

    assign soft_active   = (cnt != '0);
    assign sec_rst       = soft_active | restart_s;
    assign frm_param_clr = soft_active;
    assign dl_param_clr  = soft_active | restart_s;
    assign reframe       = (rfr_req_s != rfr_req_q);
    assign tx_sync       = sync_in & ~(mask_s & seen_sync);

    always_ff @(posedge lclk) begin
        if (lrst) begin
            cnt        <= '0;
            srst_req_q <= 1'b0;
            rfr_req_q  <= 1'b0;
            srst_ack   <= 1'b0;
        end else begin
            srst_req_q <= srst_req_s;
            rfr_req_q  <= rfr_req_s;
            if (srst_req_s != srst_req_q) begin
                cnt <= CW'(SRST_CYCLES);
            end else if (soft_active) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) srst_ack <= ~srst_ack;
            end
        end
    end

    // Transmit counters restart on any section reset, so the mask re-arms.
    always_ff @(posedge lclk) begin
        if (lrst || sec_rst) seen_sync <= 1'b0;
        else if (sync_in)    seen_sync <= 1'b1;
    end
endmodule

// File: rtl/frm_transp.sv
module frm_transp
    import frm_ctrl_pkg::*;
(
    input  logic    lclk,
    input  logic    lrst,
    input  transp_e mode,
    input  logic    e1_mode,
    input  logic    sys_ts0b7,
    input  logic    line_fpos,
    input  logic    sys_in,
    input  logic    tx_framed,
    input  logic    line_in,
    input  logic    rx_framed,
    output logic    line_out,
    output logic    sys_out
);
    logic tx_fhold;
    logic rx_fhold;
    logic tx_pass;
    logic rx_pass;

    always_ff @(posedge lclk) begin
        if (lrst) begin
            tx_fhold <= 1'b0;
            rx_fhold <= 1'b0;
        end else begin
            if (sys_ts0b7) tx_fhold <= sys_in;
            if (line_fpos) rx_fhold <= line_in;
        end
    end

    always_comb begin
        tx_pass = (mode != PASS_NONE);
        rx_pass = (mode == PASS_BOTH);

        if (!tx_pass)                  line_out = tx_framed;
        else if (!e1_mode && line_fpos) line_out = tx_fhold;
        else                           line_out = sys_in;

        if (!rx_pass)                  sys_out = rx_framed;
        else if (!e1_mode && sys_ts0b7) sys_out = rx_fhold;
        else                           sys_out = line_in;
    end
endmodule

// File: rtl/frm_mode_ctrl.sv
module frm_mode_ctrl
    import frm_ctrl_pkg::*;
#(
    parameter int SRST_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             lclk,
    input  logic             lrst,
    output logic             sec_rst,
    output logic             frm_param_clr,
    output logic             dl_param_clr,
    output logic             reframe,
    output logic             align_block,
    input  logic             sync_in,
    output logic             tx_sync,
    input  logic             e1_mode,
    input  logic             sys_ts0b7,
    input  logic             line_fpos,
    input  logic             sys_in,
    input  logic             tx_framed,
    output logic             line_out,
    input  logic             line_in,
    input  logic             rx_framed,
    output logic             sys_out
);
    localparam int XW = 6;

    ctl_reg_t      ctl;
    logic          srst_req;
    logic          rfr_req;
    logic          srst_ack;
    logic          srst_ack_s;
    logic [XW-1:0] to_line;
    logic [XW-1:0] at_line;
    transp_e       mode;

    frm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .srst_ack (srst_ack_s),
        .ctl      (ctl),
        .srst_req (srst_req),
        .rfr_req  (rfr_req)
    );

    assign rd_data = ctl;
    assign to_line = {ctl.sync_mask, ctl.tx_only, ctl.bidir, ctl.restart, rfr_req, srst_req};

    frm_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_sync_fwd (
        .clk (lclk),
        .rst (lrst),
        .d   (to_line),
        .q   (at_line)
    );

    frm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
        .clk (clk),
        .rst (rst),
        .d   (srst_ack),
        .q   (srst_ack_s)
    );

    frm_line_seq #(.SRST_CYCLES(SRST_CYCLES)) u_seq (
        .lclk          (lclk),
        .lrst          (lrst),
        .srst_req_s    (at_line[0]),
        .rfr_req_s     (at_line[1]),
        .restart_s     (at_line[2]),
        .mask_s        (at_line[5]),
        .sync_in       (sync_in),
        .srst_ack      (srst_ack),
        .sec_rst       (sec_rst),
        .frm_param_clr (frm_param_clr),
        .dl_param_clr  (dl_param_clr),
        .reframe       (reframe),
        .tx_sync       (tx_sync)
    );

    assign mode        = decode_transp(at_line[3], at_line[4]);
    assign align_block = (mode == PASS_BOTH);

    frm_transp u_transp (
        .lclk      (lclk),
        .lrst      (lrst),
        .mode      (mode),
        .e1_mode   (e1_mode),
        .sys_ts0b7 (sys_ts0b7),
        .line_fpos (line_fpos),
        .sys_in    (sys_in),
        .tx_framed (tx_framed),
        .line_in   (line_in),
        .rx_framed (rx_framed),
        .line_out  (line_out),
        .sys_out   (sys_out)
    );
endmodule

// File: rtl/frm_mode_ctrl_chk.sv
module frm_mode_ctrl_chk #(
    parameter int SRST_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [4:0] wr_mid,
    input logic [7:0] rd_data,
    input logic       lclk,
    input logic       lrst,
    input logic       sec_rst,
    input logic       frm_param_clr,
    input logic       dl_param_clr,
    input logic       sync_in,
    input logic       tx_sync,
    input logic       align_block,
    input logic       e1_mode,
    input logic       sys_ts0b7,
    input logic       line_in,
    input logic       sys_out
);
    int   run;
    logic chk_seen;

    always_ff @(posedge lclk) begin
        if (lrst)               run <= 0;
        else if (frm_param_clr) run <= run + 1;
        else                    run <= 0;
    end

    always_ff @(posedge lclk) begin
        if (lrst || sec_rst) chk_seen <= 1'b0;
        else if (sync_in)    chk_seen <= 1'b1;
    end

    a_r1_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[5:1] == $past(wr_mid)) && (rd_data[7:6] == 2'b00));

    a_r2_window_len: assert property (@(posedge lclk) disable iff (lrst)
        $fell(frm_param_clr) |-> (run == SRST_CYCLES));

    a_r2_window_cap: assert property (@(posedge lclk) disable iff (lrst)
        frm_param_clr |-> (run < SRST_CYCLES));

    a_r3_restart_holds: assert property (@(posedge lclk) disable iff (lrst)
        (dl_param_clr || frm_param_clr) |-> sec_rst);

    a_r4_soft_clears_dl: assert property (@(posedge lclk) disable iff (lrst)
        frm_param_clr |-> dl_param_clr);

    a_r6_rx_copy: assert property (@(posedge lclk) disable iff (lrst)
        (align_block && !(!e1_mode && sys_ts0b7)) |-> (sys_out == line_in));

    a_r11_sync_source: assert property (@(posedge lclk) disable iff (lrst)
        tx_sync |-> sync_in);

    a_r11_mask_after_first: assert property (@(posedge lclk) disable iff (lrst)
        (sync_in && !tx_sync) |-> chk_seen);
endmodule

bind frm_mode_ctrl frm_mode_ctrl_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_mid        (wr_data[5:1]),
    .rd_data       (rd_data),
    .lclk          (lclk),
    .lrst          (lrst),
    .sec_rst       (sec_rst),
    .frm_param_clr (frm_param_clr),
    .dl_param_clr  (dl_param_clr),
    .sync_in       (sync_in),
    .tx_sync       (tx_sync),
    .align_block   (align_block),
    .e1_mode       (e1_mode),
    .sys_ts0b7     (sys_ts0b7),
    .line_in       (line_in),
    .sys_out       (sys_out)
);

// File: tb/test_frm_mode_ctrl.sv
`timescale 1ns/1ps
module test_frm_mode_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int LCLK_PERIOD = 14;
    localparam int SRST_LEN    = 4;

    logic       clk = 1'b0, lclk = 1'b0;
    logic       rst = 1'b1, lrst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sec_rst, frm_param_clr, dl_param_clr, reframe, align_block;
    logic       sync_in = 1'b0, tx_sync;
    logic       e1_mode = 1'b0, sys_ts0b7 = 1'b0, line_fpos = 1'b0;
    logic       sys_in = 1'b0, tx_framed = 1'b0, line_out;
    logic       line_in = 1'b0, rx_framed = 1'b0, sys_out;

    int checks = 0, fails = 0;
    int n_clr = 0, n_sec = 0, n_dl = 0, n_rfr = 0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(LCLK_PERIOD/2) lclk = ~lclk;

    frm_mode_ctrl #(.SRST_CYCLES(SRST_LEN)) i_frm_mode_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .lclk(lclk), .lrst(lrst), .sec_rst(sec_rst), .frm_param_clr(frm_param_clr),
        .dl_param_clr(dl_param_clr), .reframe(reframe), .align_block(align_block),
        .sync_in(sync_in), .tx_sync(tx_sync), .e1_mode(e1_mode), .sys_ts0b7(sys_ts0b7),
        .line_fpos(line_fpos), .sys_in(sys_in), .tx_framed(tx_framed), .line_out(line_out),
        .line_in(line_in), .rx_framed(rx_framed), .sys_out(sys_out)
    );

    always @(negedge lclk) begin
        if (frm_param_clr) n_clr++;
        if (sec_rst)       n_sec++;
        if (dl_param_clr)  n_dl++;
        if (reframe)       n_rfr++;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lwait(input int n);
        repeat (n) @(negedge lclk);
    endtask

    task automatic wait_bit0_clear;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!rd_data[0]) break;
        end
        chk("R2 bit0 self-clear", {7'd0, rd_data[0]}, 8'h00);
        lwait(4);
    endtask

    task automatic pulse_sync(input string req, input logic exp);
        @(negedge lclk);
        sync_in = 1'b1;
        #1 chk(req, {7'd0, tx_sync}, {7'd0, exp});
        @(negedge lclk);
        sync_in = 1'b0;
    endtask

    initial begin
        int c0, s0, d0, r0;
        logic mtx, mrx;
        repeat (4) @(negedge lclk);
        rst = 1'b0; lrst = 1'b0;
        lwait(2);

        // Reset state
        chk("R1 reset value", rd_data, 8'h00);
        chk("R10 reset sec_rst", {7'd0, sec_rst}, 8'h00);
        chk("R5 reset reframe", {7'd0, reframe}, 8'h00);
        chk("R10 reset align_block", {7'd0, align_block}, 8'h00);

        // Readback with reserved bits forced to zero
        wr(8'hFE);
        chk("R1 readback FE", rd_data, 8'h3E);
        wr(8'hC0);
        chk("R1 readback C0", rd_data, 8'h00);
        wr(8'h14);
        chk("R1 readback 14", rd_data, 8'h14);
        wr(8'h00);
        lwait(8);

        // Soft reset window
        c0 = n_clr; s0 = n_sec; d0 = n_dl;
        wr(8'h01);
        chk("R2 bit0 reads 1 while busy", {7'd0, rd_data[0]}, 8'h01);
        wr(8'h01);
        wait_bit0_clear();
        chk("R2 frm_param_clr length", 8'(n_clr - c0), 8'(SRST_LEN));
        chk("R2 sec_rst length", 8'(n_sec - s0), 8'(SRST_LEN));
        chk("R2 dl_param_clr length", 8'(n_dl - d0), 8'(SRST_LEN));
        chk("R2 readback after", rd_data, 8'h00);

        // Restart held
        wr(8'h02);
        lwait(6);
        chk("R3 sec_rst held", {7'd0, sec_rst}, 8'h01);
        chk("R3 dl_param_clr held", {7'd0, dl_param_clr}, 8'h01);
        chk("R3 frm_param_clr low", {7'd0, frm_param_clr}, 8'h00);

        // Soft reset during restart
        c0 = n_clr;
        wr(8'h03);
        wait_bit0_clear();
        chk("R4 frm_param_clr length", 8'(n_clr - c0), 8'(SRST_LEN));
        chk("R4 restart kept", rd_data, 8'h02);
        chk("R4 sec_rst still high", {7'd0, sec_rst}, 8'h01);
        wr(8'h00);
        lwait(6);
        chk("R3 released", {7'd0, sec_rst}, 8'h00);
        chk("R3 dl released", {7'd0, dl_param_clr}, 8'h00);

        // Reframe edge arming
        r0 = n_rfr;
        wr(8'h04); lwait(6);
        chk("R5 first rise", 8'(n_rfr - r0), 8'd1);
        wr(8'h04); lwait(6);
        chk("R5 repeat ignored", 8'(n_rfr - r0), 8'd1);
        wr(8'h00); lwait(6);
        chk("R5 clear no pulse", 8'(n_rfr - r0), 8'd1);
        wr(8'h04); lwait(6);
        chk("R5 second rise", 8'(n_rfr - r0), 8'd2);
        wr(8'h00); lwait(6);

        // Transparency sweep over both enables, both frame types and all 64 input patterns
        mtx = 1'b0; mrx = 1'b0;
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                logic b3, b4;
                b3 = m[1]; b4 = m[0];
                @(negedge lclk);
                sys_ts0b7 = 1'b0; line_fpos = 1'b0; e1_mode = e[0];
                wr({3'b000, b4, b3, 3'b000});
                lwait(6);
                for (int v = 0; v < 64; v++) begin
                    logic el, es;
                    string rq;
                    @(negedge lclk);
                    sys_in = v[0]; line_in = v[1]; tx_framed = v[2];
                    rx_framed = v[3]; sys_ts0b7 = v[4]; line_fpos = v[5];
                    #1;
                    if (!b3 && !b4)                     el = tx_framed;
                    else if (!e1_mode && line_fpos)     el = mtx;
                    else                                el = sys_in;
                    if (!b3)                            es = rx_framed;
                    else if (!e1_mode && sys_ts0b7)     es = mrx;
                    else                                es = line_in;
                    if (!b3 && !b4)                         rq = "R10";
                    else if (e1_mode)                       rq = "R9";
                    else if (line_fpos || sys_ts0b7)        rq = "R8";
                    else if (b3)                            rq = "R6";
                    else                                    rq = "R7";
                    chk({rq, " line_out"}, {7'd0, line_out}, {7'd0, el});
                    chk({rq, " sys_out"}, {7'd0, sys_out}, {7'd0, es});
                    chk("R7 align_block priority", {7'd0, align_block}, {7'd0, b3});
                    @(posedge lclk);
                    if (sys_ts0b7) mtx = sys_in;
                    if (line_fpos) mrx = line_in;
                end
            end
        end
        @(negedge lclk);
        sys_ts0b7 = 1'b0; line_fpos = 1'b0;
        wr(8'h00); lwait(6);

        // Sync mask
        wr(8'h20); lwait(6);
        pulse_sync("R11 first pulse passes", 1'b1);
        pulse_sync("R11 later pulse masked", 1'b0);
        wr(8'h00); lwait(6);
        pulse_sync("R11 unmasked passes", 1'b1);
        wr(8'h20); lwait(6);
        pulse_sync("R11 masked after seen", 1'b0);
        wr(8'h21);
        wait_bit0_clear();
        pulse_sync("R11 rearmed after reset", 1'b1);
        pulse_sync("R11 masked again", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule